// File: doc/BRIEF.md
# Display FIFO Refill Request Generator

This block watches the free space in a video display FIFO and raises single-cycle DMA request events so the DMA engine keeps the FIFO filled. A request goes out when the free space reaches a programmable threshold. After a request is raised, the block waits until the DMA starts writing that service into the FIFO. While a service is still being written, the block can raise one more request early, but only if the free space is at least twice the threshold. At any time, no more than one request can be raised and still waiting for its first write.

Each service is tracked by a down-counter of incoming doublewords. The counter length is the threshold for a luma FIFO, or half the threshold for a chroma FIFO. When the counter reaches zero, the block flags that the service is done. A per-field budget sets how many requests may be issued in each field. The budget is reloaded at every field start.

The threshold must be at least 2 and, in chroma mode, even.

Top module: `dispDmaReqGen`

## Requirements
- R1: When no service is counting, no request is waiting, the budget is nonzero and `freeSpace >= threshold`, `dmaEvent` pulses high in the cycle after that condition is sampled.
- R2: After a request is raised, no further request is raised until the first `dmaWr` of its service has been accepted.
- R3: While a service is counting and no request is waiting, a request is raised only when `freeSpace >= 2*threshold`.
- R4: A `dmaWr` that arrives while a request is waiting and no service is counting begins a new service and counts as its first doubleword. A `dmaWr` that arrives while nothing is waiting and nothing is counting has no effect.
- R5: A service is `threshold` doublewords long when `chromaMode` is 0, and `threshold/2` doublewords long when `chromaMode` is 1. The length is taken at the service's first write.
- R6: `serviceDone` is a one-cycle pulse in the cycle after the write that brings the service's doubleword count to zero.
- R7: A `fieldStart` cycle loads the budget from `evtPerField`, and no request is raised in that cycle. Each request raised consumes one unit of budget. No request is raised while the budget is zero.
- R8: Each `dmaEvent` pulse lasts exactly one cycle. An asserted `rstN=0` clears the budget, the counter and the waiting state, and holds both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fieldStart | input | 1 | Reloads the event budget |
| evtPerField | input | EVT_W | Requests allowed per field |
| freeSpace | input | LVL_W | Free FIFO locations |
| threshold | input | THR_W | Request threshold in locations |
| chromaMode | input | 1 | 1 selects half-length chroma services |
| dmaWr | input | 1 | One doubleword written into the FIFO |
| dmaEvent | output | 1 | Request pulse to the DMA engine |
| serviceDone | output | 1 | Pulse when a service completes |

## Verification
The bench builds the block with an 8-bit free-space level, a 6-bit threshold and a 4-bit budget. These widths let `freeSpace` sweep both sides of `threshold` and `2*threshold` for thresholds of 4, 8 and 16. They also let small budgets run out within a few requests, so the zero-budget stall and its reload are reached often. Luma and chroma phases alternate. Random write strobes cover several cases: stray writes, early second requests during a long service, and one-doubleword chroma services that complete on their first write.

// File: rtl/dispDmaPkg.sv
package dispDmaPkg;
  typedef struct packed {
    logic raise;   // request issued this cycle
    logic begin_;  // first doubleword of a new service
    logic step;    // doubleword of the counting service
    logic reload;  // field start budget reload
  } ctrlStrobes_t;
endpackage

// File: rtl/dispDmaDatapath.sv
module dispDmaDatapath
  import dispDmaPkg::*;
#(
  parameter int LVL_W = 8,
  parameter int THR_W = 6,
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [EVT_W-1:0] evtPerField,
  input  logic [LVL_W-1:0] freeSpace,
  input  logic [THR_W-1:0] threshold,
  input  logic             chromaMode,
  output logic             spaceOk1,
  output logic             spaceOk2,
  output logic             cntIdle,
  output logic             budgetZero,
  output logic             serviceDone
);
  localparam int CMP_W = ((LVL_W > THR_W) ? LVL_W : THR_W) + 1;

  logic [THR_W-1:0] remain;
  logic [EVT_W-1:0] budget;
  logic [THR_W-1:0] svcLen;
  logic [CMP_W-1:0] freeWide, thrWide;

  assign freeWide   = CMP_W'(freeSpace);
  assign thrWide    = CMP_W'(threshold);
  assign spaceOk1   = freeWide >= thrWide;
  assign spaceOk2   = freeWide >= (thrWide << 1);
  assign cntIdle    = (remain == '0);
  assign budgetZero = (budget == '0);
  assign svcLen     = chromaMode ? (threshold >> 1) : threshold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain      <= '0;
      budget      <= '0;
      serviceDone <= 1'b0;
    end else begin
      serviceDone <= (strobes.begin_ && svcLen == THR_W'(1)) ||
                     (strobes.step && remain == THR_W'(1));
      if (strobes.begin_)    remain <= svcLen - THR_W'(1);
      else if (strobes.step) remain <= remain - THR_W'(1);
      if (strobes.reload)     budget <= evtPerField;
      else if (strobes.raise) budget <= budget - EVT_W'(1);
    end
  end

  // R6
  count_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |-> remain != '0);
  // R7
  budget_spend_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.raise |-> budget != '0);
  // R6
  done_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    serviceDone |-> remain == '0);
endmodule

// File: rtl/dispDmaCtrl.sv
module dispDmaCtrl
  import dispDmaPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fieldStart,
  input  logic         dmaWr,
  input  logic         spaceOk1,
  input  logic         spaceOk2,
  input  logic         cntIdle,
  input  logic         budgetZero,
  output ctrlStrobes_t strobes,
  output logic         dmaEvent
);
  logic pending;
  logic spaceOk;

  assign spaceOk = cntIdle ? spaceOk1 : spaceOk2;

  always_comb begin
    strobes        = '0;
    strobes.reload = fieldStart;
    strobes.raise  = !fieldStart && !budgetZero && !pending && spaceOk;
    strobes.begin_ = dmaWr && pending && cntIdle;
    strobes.step   = dmaWr && !cntIdle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      dmaEvent <= 1'b0;
    end else begin
      dmaEvent <= strobes.raise;
      if (strobes.raise)       pending <= 1'b1;
      else if (strobes.begin_) pending <= 1'b0;
    end
  end

  // R8
  event_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaEvent |=> !dmaEvent);
  // R2
  pending_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !$past(pending)) |-> dmaEvent);
endmodule

// File: rtl/dispDmaReqGen.sv
module dispDmaReqGen
  import dispDmaPkg::*;
#(
  parameter int LVL_W = 8,
  parameter int THR_W = 6,
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fieldStart,
  input  logic [EVT_W-1:0] evtPerField,
  input  logic [LVL_W-1:0] freeSpace,
  input  logic [THR_W-1:0] threshold,
  input  logic             chromaMode,
  input  logic             dmaWr,
  output logic             dmaEvent,
  output logic             serviceDone
);
  ctrlStrobes_t strobes;
  logic spaceOk1, spaceOk2, cntIdle, budgetZero;

  dispDmaCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .dmaWr(dmaWr),
    .spaceOk1(spaceOk1), .spaceOk2(spaceOk2), .cntIdle(cntIdle),
    .budgetZero(budgetZero), .strobes(strobes), .dmaEvent(dmaEvent)
  );

  dispDmaDatapath #(.LVL_W(LVL_W), .THR_W(THR_W), .EVT_W(EVT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evtPerField(evtPerField),
    .freeSpace(freeSpace), .threshold(threshold), .chromaMode(chromaMode),
    .spaceOk1(spaceOk1), .spaceOk2(spaceOk2), .cntIdle(cntIdle),
    .budgetZero(budgetZero), .serviceDone(serviceDone)
  );
endmodule

// File: tb/dispDmaReqGen_tb.sv
module dispDmaReqGen_tb_top;
  localparam int LVL_W = 8, THR_W = 6, EVT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fieldStart = 1'b0;
  logic [EVT_W-1:0] evtPerField = '0;
  logic [LVL_W-1:0] freeSpace = '0;
  logic [THR_W-1:0] threshold = 6'd8;
  logic chromaMode = 1'b0;
  logic dmaWr = 1'b0;
  logic dmaEvent, serviceDone;

  int checks = 0, fails = 0;
  int pendM = 0, remainM = 0, budgetM = 0;
  bit expEvt = 0, expDone = 0;
  string evtTag = "R8", doneTag = "R8";
  bit finished = 0;

  always #2 clk = ~clk;

  dispDmaReqGen #(.LVL_W(LVL_W), .THR_W(THR_W), .EVT_W(EVT_W)) dut_i (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .evtPerField(evtPerField),
    .freeSpace(freeSpace), .threshold(threshold), .chromaMode(chromaMode),
    .dmaWr(dmaWr), .dmaEvent(dmaEvent), .serviceDone(serviceDone)
  );

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference, evaluated on every rising edge
  always @(posedge clk) begin
    int thr, len;
    bit idle, raiseM, beginM, stepM, strayM;
    thr = int'(threshold);
    len = chromaMode ? thr / 2 : thr;
    if (!rstN) begin
      pendM = 0; remainM = 0; budgetM = 0;
      expEvt = 0; expDone = 0; evtTag = "R8"; doneTag = "R8";
    end else begin
      idle   = (remainM == 0);
      raiseM = !fieldStart && budgetM > 0 && pendM == 0 &&
               (idle ? int'(freeSpace) >= thr : int'(freeSpace) >= 2 * thr);
      beginM = dmaWr && pendM == 1 && idle;
      stepM  = dmaWr && !idle;
      strayM = dmaWr && pendM == 0 && idle;
      expDone = (beginM && len == 1) || (stepM && remainM == 1);
      if (raiseM) evtTag = idle ? "R1" : "R3";
      else if (pendM == 1) evtTag = "R2";
      else if (fieldStart || budgetM == 0) evtTag = "R7";
      else evtTag = idle ? "R1" : "R3";
      doneTag = strayM ? "R4" : (beginM ? "R5" : "R6");
      if (fieldStart) budgetM = int'(evtPerField);
      else if (raiseM) budgetM--;
      if (beginM) remainM = len - 1;
      else if (stepM) remainM--;
      if (raiseM) pendM = 1;
      else if (beginM) pendM = 0;
      expEvt = raiseM;
    end
    #1;
    if (!finished) begin
      check(evtTag, dmaEvent, expEvt);
      check(doneTag, serviceDone, expDone);
    end
  end

  task automatic runPhase(input int cycles, input int thrVal, input bit chroma,
                          input int wrPct, input int fsPct);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      threshold   = THR_W'(thrVal);
      chromaMode  = chroma;
      freeSpace   = LVL_W'($urandom_range(0, 3 * thrVal + 4));
      dmaWr       = ($urandom_range(0, 99) < wrPct);
      fieldStart  = ($urandom_range(0, 99) < fsPct);
      evtPerField = EVT_W'($urandom_range(0, 6));
    end
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    // R8: reset state, outputs low
    check("R8", dmaEvent, 1'b0);
    check("R8", serviceDone, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // R7: zero budget before any field start blocks requests
    freeSpace = 8'd200;
    repeat (4) @(negedge clk);
    fieldStart = 1'b1; evtPerField = 4'd2;
    @(negedge clk);
    fieldStart = 1'b0;
    repeat (6) @(negedge clk);
    // R4/R5/R6: service walk with luma length
    repeat (10) begin @(negedge clk); dmaWr = 1'b1; end
    dmaWr = 1'b0;
    runPhase(1500, 8, 1'b0, 50, 3);
    runPhase(1500, 4, 1'b1, 40, 3);
    runPhase(1500, 16, 1'b0, 70, 2);
    runPhase(1000, 2, 1'b1, 50, 4);
    // R8: mid-run reset clears state
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R8", dmaEvent, 1'b0);
    check("R8", serviceDone, 1'b0);
    rstN = 1'b1;
    runPhase(800, 8, 1'b1, 60, 3);
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R8 watchdog expired: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule